// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block monitors every bus cycle that a master presents and raises a break request when the cycle meets a programmed condition. There are two watch channels, A and B. Each channel checks four things. The first is a compare address, with a per-bit exclusion mask. The second is an 8-bit address-space identifier. The third is the cycle kind: which master drives it (processor or DMA engine), whether it is an instruction fetch or a data access, and whether it reads or writes. The fourth, optionally, is the operand size. Channel B can also check the transferred data under a don't-care mask. That data check is limited to the byte lanes the access carries.

The channels can report on their own: either match raises the break. They can also be chained, so that the break needs a channel A match in some earlier cycle followed by a channel B match. In the chained form, a single cycle that satisfies both channels is not an ordered pair. The exception is when channel A watches instruction fetches and is marked as a before-execution breakpoint; then that single cycle does fire. A register write port loads the conditions. Two sticky match flags, set when a break is issued, are visible as outputs and can be written through the control register.

Top module: `bus_break_unit`

## Requirements
- R1: Writes take effect when `cfg_we` is 1. `cfg_sel` picks the register: 0 is the A compare address, 1 the A address mask, 2 the A attribute word, 3 the B compare address, 4 the B address mask, 5 the B attribute word, 6 the B compare data, 7 the B data mask and 8 the control word. Attribute bits are [0] enable, [1] DMA master, [2] instruction fetch, [3] write, [5:4] size, [6] size check on, [7] data check on (B only) and [15:8] identifier. Control bits are [0] sequential mode, [1] channel A before-execution, [2] flag A value and [3] flag B value. With `cfg_we` at 0, the control settings do not change.
- R2: An address bit whose mask bit is 1 plays no part in the address comparison. Every other bit must be equal.
- R3: Sizes are encoded as 0 = byte, 1 = word (2 bytes) and 2 or 3 = longword (4 bytes). An access covers the naturally aligned bytes of its size that contain `bus_addr`. It hits the compare address when that address lies inside those bytes. A longword at 0x...54 therefore hits 0x...56, while a byte at 0x...57 does not.
- R4: The 8-bit `bus_asid` must equal the channel's programmed identifier.
- R5: A channel matches only when it is enabled, `bus_valid` is 1, and `bus_dma`, `bus_ifetch` and `bus_write` equal the channel's master, fetch and write bits.
- R6: With the size check on, `bus_size` must equal the programmed size. With it off, any size matches.
- R7: With B's data check on, a data bit whose mask bit is 1 is a don't-care. Only bits [7:0] are compared for a byte access, bits [15:0] for a word and bits [31:0] for a longword. For example, data 0x78 with mask 0x0F accepts byte values 0x70 to 0x7F.
- R8: A channel programmed for the DMA master together with instruction fetch never matches.
- R9: In independent mode (control bit 0 = 0), any match on A or B issues a break. Flag A and flag B are set by their own channel's match.
- R10: In sequential mode, a break is issued only on a B match in a cycle later than a cycle that matched A. A lone cycle that matches both channels issues no break, although its A match arms the sequence. On a sequential break both flags become 1.
- R11: In sequential mode with channel A before-execution (control bit 1) and A watching instruction fetches, a single cycle matching both channels issues the break and sets both flags.
- R12: The armed state (`seq_armed`) is cleared by a sequential break and by any control write. A control write also loads the flags from bits [3:2]. Independent mode keeps it at 0.
- R13: After reset, all registers, flags, `seq_armed` and `brk_req` are 0. `brk_req` is a one-clock pulse in the cycle after the matching `bus_valid` cycle, and the flags and `seq_armed` update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | AW | Cycle byte address |
| bus_asid | input | 8 | Cycle address-space identifier |
| bus_dma | input | 1 | 1 = DMA master, 0 = processor |
| bus_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size code |
| bus_data | input | DW | Cycle data |
| brk_req | output | 1 | Break request pulse |
| flag_a | output | 1 | Sticky channel A match flag |
| flag_b | output | 1 | Sticky channel B match flag |
| seq_armed | output | 1 | Channel A seen, waiting for channel B |

## Verification
The bench builds the block with its default widths: a 32-bit address and 32-bit data. The full-width address lets a mask open a middle nibble while a match is checked far from the compare value. The full-width data lets it place junk in the upper byte lanes of byte and word writes and confirm that those lanes are ignored. These widths also give room for the ordered, simultaneous and before-execution cases of the chained mode, each driven against a fresh set of conditions.

// File: rtl/bbk_pkg.sv
package bbk_pkg;

    localparam int ASID_W    = 8;
    localparam int SEL_W     = 4;
    localparam int NCH       = 2;
    localparam int CH_A      = 0;
    localparam int CH_B      = 1;
    localparam int SIZE_W    = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONX = 2'd3
    } bbk_size_e;

    // Attribute word, bit 0 is en
    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic              data_en;
        logic              size_en;
        logic [SIZE_W-1:0] size;
        logic              wr;
        logic              fetch;
        logic              dma;
        logic              en;
    } bbk_attr_t;

    // Control word, bit 0 is seq
    typedef struct packed {
        logic flag_b;
        logic flag_a;
        logic pre_exec;
        logic seq;
    } bbk_ctrl_t;

    localparam int ATTR_W = $bits(bbk_attr_t);
    localparam int CTRL_W = $bits(bbk_ctrl_t);

    typedef enum logic [SEL_W-1:0] {
        SEL_A_ADDR = 4'd0,
        SEL_A_AMSK = 4'd1,
        SEL_A_ATTR = 4'd2,
        SEL_B_ADDR = 4'd3,
        SEL_B_AMSK = 4'd4,
        SEL_B_ATTR = 4'd5,
        SEL_B_DATA = 4'd6,
        SEL_B_DMSK = 4'd7,
        SEL_CTRL   = 4'd8
    } bbk_sel_e;

endpackage

// File: rtl/bbk_regs.sv
module bbk_regs
    import bbk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int WW = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [SEL_W-1:0]             sel,
    input  logic [WW-1:0]                wdata,
    output logic [NCH-1:0][AW-1:0]       cmp_addr,
    output logic [NCH-1:0][AW-1:0]       cmp_amsk,
    output bbk_attr_t [NCH-1:0]          cmp_attr,
    output logic [DW-1:0]                cmp_data,
    output logic [DW-1:0]                cmp_dmsk,
    output logic                         seq_mode,
    output logic                         pre_exec,
    output logic                         ctrl_wr,
    output logic [1:0]                   ctrl_flags
);

    typedef struct packed {
        logic [NCH-1:0][AW-1:0] addr;
        logic [NCH-1:0][AW-1:0] amsk;
        bbk_attr_t [NCH-1:0]    attr;
        logic [DW-1:0]          data;
        logic [DW-1:0]          dmsk;
        logic                   seq;
        logic                   pre;
    } regs_t;

    regs_t     r_d, r_q;
    bbk_ctrl_t ctrl_w;

    always_comb begin
        r_d        = r_q;
        ctrl_w     = bbk_ctrl_t'(wdata[CTRL_W-1:0]);
        ctrl_wr    = 1'b0;
        if (we) begin
            case (sel)
                SEL_A_ADDR: r_d.addr[CH_A] = wdata[AW-1:0];
                SEL_A_AMSK: r_d.amsk[CH_A] = wdata[AW-1:0];
                SEL_A_ATTR: r_d.attr[CH_A] = bbk_attr_t'(wdata[ATTR_W-1:0]);
                SEL_B_ADDR: r_d.addr[CH_B] = wdata[AW-1:0];
                SEL_B_AMSK: r_d.amsk[CH_B] = wdata[AW-1:0];
                SEL_B_ATTR: r_d.attr[CH_B] = bbk_attr_t'(wdata[ATTR_W-1:0]);
                SEL_B_DATA: r_d.data       = wdata[DW-1:0];
                SEL_B_DMSK: r_d.dmsk       = wdata[DW-1:0];
                SEL_CTRL: begin
                    r_d.seq = ctrl_w.seq;
                    r_d.pre = ctrl_w.pre_exec;
                    ctrl_wr = 1'b1;
                end
                default: ;
            endcase
        end
        ctrl_flags = {ctrl_w.flag_b, ctrl_w.flag_a};
        cmp_addr   = r_q.addr;
        cmp_amsk   = r_q.amsk;
        cmp_attr   = r_q.attr;
        cmp_data   = r_q.data;
        cmp_dmsk   = r_q.dmsk;
        seq_mode   = r_q.seq;
        pre_exec   = r_q.pre;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R1: control settings only move on a write
    assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(seq_mode) && $stable(pre_exec)));

endmodule

// File: rtl/bbk_chan_cmp.sv
module bbk_chan_cmp
    import bbk_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cmp_addr,
    input  logic [AW-1:0]     cmp_amsk,
    input  bbk_attr_t         attr,
    input  logic [DW-1:0]     cmp_data,
    input  logic [DW-1:0]     cmp_dmsk,
    input  logic              bus_valid,
    input  logic [AW-1:0]     bus_addr,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic              bus_dma,
    input  logic              bus_ifetch,
    input  logic              bus_write,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DW-1:0]     bus_data,
    output logic              hit
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [AW-1:0] cover_m;
    logic          addr_ok, asid_ok, kind_ok, size_ok, legal_ok, data_ok;

    always_comb begin
        cover_m = '0;
        case (bbk_size_e'(bus_size))
            SZ_BYTE: cover_m = '0;
            SZ_WORD: cover_m[0] = 1'b1;
            default: cover_m[1:0] = 2'b11;
        endcase
        addr_ok  = ((bus_addr ^ cmp_addr) & ~(cmp_amsk | cover_m)) == '0;
        asid_ok  = (bus_asid == attr.asid);
        kind_ok  = (bus_dma == attr.dma) && (bus_ifetch == attr.fetch)
                   && (bus_write == attr.wr);
        size_ok  = !attr.size_en || (bus_size == attr.size);
        legal_ok = !(attr.dma && attr.fetch);
    end

    generate
        if (HAS_DATA) begin : g_data
            logic [DW-1:0] lane_m;
            always_comb begin
                case (bbk_size_e'(bus_size))
                    SZ_BYTE: lane_m = {DW{1'b1}} << BYTE_W;
                    SZ_WORD: lane_m = {DW{1'b1}} << HALF_W;
                    default: lane_m = '0;
                endcase
                data_ok = !attr.data_en
                          || (((bus_data ^ cmp_data) & ~(cmp_dmsk | lane_m)) == '0);
            end
        end else begin : g_nodata
            logic data_unused;
            assign data_unused = ^{cmp_data, cmp_dmsk, bus_data, attr.data_en};
            assign data_ok     = 1'b1;
        end
    endgenerate

    assign hit = bus_valid && attr.en && legal_ok && addr_ok && asid_ok
                 && kind_ok && size_ok && data_ok;

    // R4: identifier always agrees on a hit
    assert_asid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (bus_asid == attr.asid));
    // R5: no hit without an enabled channel and a live cycle
    assert_hit_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (bus_valid && attr.en && bus_write == attr.wr));
    // R8: DMA plus fetch never hits
    assert_dma_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (attr.dma && attr.fetch) |-> !hit);

endmodule

// File: rtl/bbk_seq.sv
module bbk_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_valid,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic       a_fetch,
    input  logic       seq_mode,
    input  logic       pre_exec,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_flags,
    output logic       brk_req,
    output logic       flag_a,
    output logic       flag_b,
    output logic       seq_armed
);

    typedef struct packed {
        logic a_seen;
        logic flag_a;
        logic flag_b;
        logic brk;
    } seq_t;

    seq_t s_d, s_q;
    logic pre_ok, seq_fire, fire;

    always_comb begin
        pre_ok   = pre_exec && a_fetch && hit_a && hit_b;
        seq_fire = hit_b && (s_q.a_seen || pre_ok);
        fire     = seq_mode ? seq_fire : (hit_a || hit_b);

        s_d      = s_q;
        s_d.brk  = fire;
        if (ctrl_wr) begin
            s_d.flag_a = ctrl_flags[0];
            s_d.flag_b = ctrl_flags[1];
        end
        if (seq_mode) begin
            if (seq_fire) begin
                s_d.flag_a = 1'b1;
                s_d.flag_b = 1'b1;
            end
        end else begin
            s_d.flag_a = s_d.flag_a || hit_a;
            s_d.flag_b = s_d.flag_b || hit_b;
        end

        if (ctrl_wr || !seq_mode || seq_fire) s_d.a_seen = 1'b0;
        else if (hit_a)                       s_d.a_seen = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign brk_req   = s_q.brk;
    assign flag_a    = s_q.flag_a;
    assign flag_b    = s_q.flag_b;
    assign seq_armed = s_q.a_seen;

    // R13: a break pulse always follows a valid cycle
    assert_brk_after_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(bus_valid));
    // R10: in sequential mode no break without a channel B hit
    assert_seq_needs_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && !hit_b) |=> !brk_req);
    // R9: a break leaves at least one flag set
    assert_flag_on_brk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (flag_a || flag_b));
    // R9: independent channel A hit sets its flag
    assert_ind_flag_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_mode && hit_a) |=> flag_a);
    // R12: a sequential break disarms the sequence
    assert_rearm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && $past(seq_mode)) |-> !seq_armed);

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
    import bbk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              bus_valid,
    input  logic [AW-1:0]     bus_addr,
    input  logic [7:0]        bus_asid,
    input  logic              bus_dma,
    input  logic              bus_ifetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [DW-1:0]     bus_data,
    output logic              brk_req,
    output logic              flag_a,
    output logic              flag_b,
    output logic              seq_armed
);

    localparam int WW = 32;

    logic [NCH-1:0][AW-1:0] cmp_addr, cmp_amsk;
    bbk_attr_t [NCH-1:0]    cmp_attr;
    logic [DW-1:0]          cmp_data, cmp_dmsk;
    logic                   seq_mode, pre_exec, ctrl_wr;
    logic [1:0]             ctrl_flags;
    logic [NCH-1:0]         hit;

    bbk_regs #(.AW(AW), .DW(DW), .WW(WW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .cmp_addr   (cmp_addr),
        .cmp_amsk   (cmp_amsk),
        .cmp_attr   (cmp_attr),
        .cmp_data   (cmp_data),
        .cmp_dmsk   (cmp_dmsk),
        .seq_mode   (seq_mode),
        .pre_exec   (pre_exec),
        .ctrl_wr    (ctrl_wr),
        .ctrl_flags (ctrl_flags)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            bbk_chan_cmp #(.AW(AW), .DW(DW), .HAS_DATA(c == CH_B)) u_cmp (
                .clk        (clk),
                .rst_n      (rst_n),
                .cmp_addr   (cmp_addr[c]),
                .cmp_amsk   (cmp_amsk[c]),
                .attr       (cmp_attr[c]),
                .cmp_data   (cmp_data),
                .cmp_dmsk   (cmp_dmsk),
                .bus_valid  (bus_valid),
                .bus_addr   (bus_addr),
                .bus_asid   (bus_asid),
                .bus_dma    (bus_dma),
                .bus_ifetch (bus_ifetch),
                .bus_write  (bus_write),
                .bus_size   (bus_size),
                .bus_data   (bus_data),
                .hit        (hit[c])
            );
        end
    endgenerate

    bbk_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .hit_a      (hit[CH_A]),
        .hit_b      (hit[CH_B]),
        .a_fetch    (cmp_attr[CH_A].fetch),
        .seq_mode   (seq_mode),
        .pre_exec   (pre_exec),
        .ctrl_wr    (ctrl_wr),
        .ctrl_flags (ctrl_flags),
        .brk_req    (brk_req),
        .flag_a     (flag_a),
        .flag_b     (flag_b),
        .seq_armed  (seq_armed)
    );

endmodule

// File: tb/bus_break_unit_test.sv
module bus_break_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_asid = '0;
    logic        bus_dma = 1'b0;
    logic        bus_ifetch = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_data = '0;
    logic        brk_req, flag_a, flag_b, seq_armed;

    bus_break_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_asid(bus_asid), .bus_dma(bus_dma), .bus_ifetch(bus_ifetch),
        .bus_write(bus_write), .bus_size(bus_size), .bus_data(bus_data),
        .brk_req(brk_req), .flag_a(flag_a), .flag_b(flag_b), .seq_armed(seq_armed)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int         due;
        logic [3:0] e;       // {brk, flag_a, flag_b, armed}
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    localparam logic [1:0] BYTE = 2'd0, WORD = 2'd1, LONG = 2'd2;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {brk,fa,fb,armed} actual %b expected %b", tag, act, exp);
        end
    endfunction

    // monitor: compare results as they come due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            exp_t it;
            it = sbq.pop_front();
            chk(it.tag, {brk_req, flag_a, flag_b, seq_armed}, it.e);
        end
    end

    function automatic logic [31:0] at(input logic en, input logic dma, input logic fch,
                                       input logic w, input logic [1:0] sz,
                                       input logic sz_en, input logic d_en,
                                       input logic [7:0] id);
        return {16'h0, id, d_en, sz_en, sz, w, fch, dma, en};
    endfunction

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d; bus_valid = 1'b0;
    endtask

    task automatic clr(input logic sq, input logic pre);
        wr(4'd8, {28'h0, 2'b00, pre, sq});
    endtask

    // driver: present one bus cycle and push its expected result
    task automatic bc(input logic v, input logic [31:0] a, input logic [7:0] id,
                      input logic dm, input logic f, input logic w,
                      input logic [1:0] sz, input logic [31:0] dt,
                      input logic [3:0] exp, input string tag);
        exp_t it;
        @(negedge clk);
        cfg_we = 1'b0;
        bus_valid = v; bus_addr = a; bus_asid = id; bus_dma = dm;
        bus_ifetch = f; bus_write = w; bus_size = sz; bus_data = dt;
        it.due = cyc + 1; it.e = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R13 reset state", {brk_req, flag_a, flag_b, seq_armed}, 4'b0000);
        rst_n = 1'b1;

        // channel A: processor data read at 0x00123456, id 0x80
        wr(4'd0, 32'h0012_3456);
        wr(4'd1, 32'h0);
        wr(4'd2, at(1, 0, 0, 0, BYTE, 0, 0, 8'h80));
        bc(1, 32'h0012_3454, 8'h80, 0, 0, 0, LONG, 0, 4'b1100, "R3 long covers compare");
        clr(0, 0);
        bc(1, 32'h0012_3456, 8'h80, 0, 0, 0, WORD, 0, 4'b1100, "R3 word hit");
        clr(0, 0);
        bc(1, 32'h0012_3457, 8'h80, 0, 0, 0, BYTE, 0, 4'b0000, "R3 byte outside");
        bc(1, 32'h0012_3456, 8'h81, 0, 0, 0, BYTE, 0, 4'b0000, "R4 id mismatch");
        bc(1, 32'h0012_3456, 8'h80, 0, 0, 1, BYTE, 0, 4'b0000, "R5 direction");
        bc(1, 32'h0012_3456, 8'h80, 1, 0, 0, BYTE, 0, 4'b0000, "R5 master");
        bc(1, 32'h0012_3456, 8'h80, 0, 1, 0, BYTE, 0, 4'b0000, "R5 cycle type");
        bc(0, 32'h0012_3456, 8'h80, 0, 0, 0, BYTE, 0, 4'b0000, "R13 no valid");

        wr(4'd1, 32'h0000_00F0);
        bc(1, 32'h0012_34A6, 8'h80, 0, 0, 0, BYTE, 0, 4'b1100, "R2 masked bits ignored");
        clr(0, 0);
        bc(1, 32'h0012_3556, 8'h80, 0, 0, 0, BYTE, 0, 4'b0000, "R2 unmasked bit differs");

        wr(4'd1, 32'h0);
        wr(4'd2, at(1, 0, 0, 0, WORD, 1, 0, 8'h80));
        bc(1, 32'h0012_3454, 8'h80, 0, 0, 0, LONG, 0, 4'b0000, "R6 size mismatch");
        bc(1, 32'h0012_3456, 8'h80, 0, 0, 0, WORD, 0, 4'b1100, "R6 size match");
        clr(0, 0);
        wr(4'd2, at(0, 0, 0, 0, WORD, 1, 0, 8'h80));
        bc(1, 32'h0012_3456, 8'h80, 0, 0, 0, WORD, 0, 4'b0000, "R5 disabled");
        wr(4'd2, at(1, 1, 1, 0, BYTE, 0, 0, 8'h80));
        bc(1, 32'h0012_3456, 8'h80, 1, 1, 0, BYTE, 0, 4'b0000, "R8 DMA fetch never");
        wr(4'd2, 32'h0);

        // channel B: DMA byte write 0x00055555, id 0x70, data 0x7X
        wr(4'd3, 32'h0005_5555);
        wr(4'd4, 32'h0);
        wr(4'd5, at(1, 1, 0, 1, BYTE, 1, 1, 8'h70));
        wr(4'd6, 32'h0000_0078);
        wr(4'd7, 32'h0000_000F);
        bc(1, 32'h0005_5555, 8'h70, 1, 0, 1, BYTE, 32'hFFFF_FF7A, 4'b1010, "R7 byte lane data");
        clr(0, 0);
        bc(1, 32'h0005_5555, 8'h70, 1, 0, 1, BYTE, 32'h0000_0068, 4'b0000, "R7 data mismatch");
        bc(1, 32'h0005_5555, 8'h70, 0, 0, 1, BYTE, 32'h0000_007A, 4'b0000, "R5 B master");
        wr(4'd5, at(1, 1, 0, 1, WORD, 1, 1, 8'h70));
        bc(1, 32'h0005_5554, 8'h70, 1, 0, 1, WORD, 32'hABCD_0072, 4'b1010, "R7 word lane data");
        clr(0, 0);
        bc(1, 32'h0005_5554, 8'h70, 1, 0, 1, WORD, 32'h0000_1272, 4'b0000, "R7 word upper byte");
        wr(4'd5, at(1, 1, 0, 1, BYTE, 1, 1, 8'h70));

        // sequential: A = processor read 0x1000
        wr(4'd0, 32'h0000_1000);
        wr(4'd2, at(1, 0, 0, 0, BYTE, 0, 0, 8'h70));
        clr(1, 0);
        bc(1, 32'h0005_5555, 8'h70, 1, 0, 1, BYTE, 32'h7A, 4'b0000, "R10 B without A");
        bc(1, 32'h0000_1000, 8'h70, 0, 0, 0, BYTE, 0, 4'b0001, "R10 A arms");
        bc(0, 32'h0, 8'h00, 0, 0, 0, BYTE, 0, 4'b0001, "R10 armed holds");
        bc(1, 32'h0005_5555, 8'h70, 1, 0, 1, BYTE, 32'h7A, 4'b1110, "R10 A then B fires");
        bc(1, 32'h0005_5555, 8'h70, 1, 0, 1, BYTE, 32'h7A, 4'b0110, "R12 break disarms");
        clr(1, 0);
        bc(1, 32'h0000_1000, 8'h70, 0, 0, 0, BYTE, 0, 4'b0001, "R10 A arms again");
        clr(1, 0);
        bc(0, 32'h0, 8'h00, 0, 0, 0, BYTE, 0, 4'b0000, "R12 control write disarms");
        bc(1, 32'h0005_5555, 8'h70, 1, 0, 1, BYTE, 32'h7A, 4'b0000, "R12 B after disarm");

        // simultaneous: A set to the same DMA write as B
        wr(4'd0, 32'h0005_5555);
        wr(4'd2, at(1, 1, 0, 1, BYTE, 1, 0, 8'h70));
        bc(1, 32'h0005_5555, 8'h70, 1, 0, 1, BYTE, 32'h7A, 4'b0001, "R10 same cycle no break");
        clr(0, 0);
        bc(1, 32'h0005_5555, 8'h70, 1, 0, 1, BYTE, 32'h7A, 4'b1110, "R9 independent both");
        clr(0, 0);

        // before-execution on fetches
        wr(4'd0, 32'h0000_2000);
        wr(4'd2, at(1, 0, 1, 0, LONG, 0, 0, 8'h70));
        wr(4'd3, 32'h0000_2000);
        wr(4'd5, at(1, 0, 1, 0, LONG, 0, 0, 8'h70));
        clr(1, 1);
        bc(1, 32'h0000_2000, 8'h70, 0, 1, 0, LONG, 0, 4'b1110, "R11 pre-exec same cycle");
        clr(1, 0);
        bc(1, 32'h0000_2000, 8'h70, 0, 1, 0, LONG, 0, 4'b0001, "R11 without pre-exec");
        wr(4'd8, 32'h0000_000C);
        bc(0, 32'h0, 8'h00, 0, 0, 0, BYTE, 0, 4'b0110, "R12 flags loaded by write");
        bc(0, 32'h0, 8'h00, 0, 0, 0, BYTE, 0, 4'b0110, "R1 control held");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule